// File: doc/BRIEF.md
# Byte-FIFO SPI Master

This block is a memory-mapped SPI master for a 32-bit register bus. Software fills a 64-entry transmit byte queue, writes how many bytes the next burst moves, and then sets a start bit in the control word. The block shifts that many bytes out on the serial data output, most significant bit first. For every byte it sends, it captures one byte from the serial data input into a 64-entry receive queue. The start bit reads back as 1 while the burst runs and clears itself when the last byte has been stored, so software simply polls it.

The serial clock rate comes from outside: every cycle in which `sclk_tick` is high advances the serial clock by one half period. Clock polarity and phase are selectable. One of four chip-select lines can be chosen, with a programmable active level. That line is asserted automatically for the length of a burst, or it can be held at a level written by software, independent of any transfer.

The shift engine is a five-state machine:
- IDLE: holds the clock at its polarity. On start it moves to LOAD.
- LOAD: takes the next byte from the queue, or a zero byte, and moves to LEAD.
- LEAD: waits for a tick, makes the leading clock edge and moves to TRAIL.
- TRAIL: waits for a tick, makes the trailing edge, then returns to LEAD, or goes to STORE after the eighth bit.
- STORE: pushes the received byte, then returns to LOAD, or goes to IDLE after the last byte.

Top module: `spim_fifo_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x08) reads 0 and the fill-level word (offset 0x28) reads 0. The serial clock is 0 and all four chip-select lines are 0 (active-high polarity is the reset default).
- R2: The burst-length word (0x20) and the send-length word (0x24) each keep 24 bits. Writing 0xFFFFFFFF reads back 0x00FFFFFF.
- R3: A write to offset 0x04 pushes `bus_wdata[7:0]` into the transmit queue. A write to a queue already holding 64 bytes is dropped, and the level stays 64.
- R4: A read of offset 0x00 returns the oldest received byte in bits 7:0 and removes it. A read of an empty receive queue returns 0 and leaves the level at 0.
- R5: In the fill-level word, bits 6:0 give the receive queue level and bits 22:16 give the transmit queue level.
- R6: Writing 1 to control bit 8 empties the transmit queue, and writing 1 to bit 9 empties the receive queue. Both bits read back 0.
- R7: Control bit 10 starts a burst when it is written as 1 together with enable bit 0 and the burst length is non-zero. It reads 1 until the burst finishes and then clears itself. With bit 0 at 0 the write is ignored and bit 10 reads 0.
- R8: A burst moves exactly the burst-length number of bytes, 8 bits each, MSB first, and stores one received byte per byte sent.
- R9: Control bit 3 sets the clock idle level, and the clock rests there whenever no burst runs. Control bit 2 = 0 samples the input on the leading edge and launches data on the trailing edge. Bit 2 = 1 launches data on the leading edge and samples on the trailing edge.
- R10: Bytes beyond the send length, or sent while the transmit queue is empty, are 0x00.
- R11: Control bits 13:12 select one of the four lines. Bit 4 = 1 makes the active level 0, and unselected lines stay inactive. Bit 16 = 0 asserts the selected line while a burst runs. Bit 16 = 1 drives the selected line to the value of bit 17.
- R12: During a burst, the serial clock changes only in the cycle after a cycle with `sclk_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk_tick | input | 1 | Half-period advance of the serial clock |
| miso | input | 1 | Serial data from the selected device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the selected device |
| cs_line | output | 4 | Chip-select lines |

## Verification
An engine state that is out of step shows on the serial pins within one tick: a wrong edge count leaves the clock away from its idle level when the start bit clears, and a wrong phase corrupts the very first bit the bench slave samples. A queue pointer or level that is wrong shows at the next read of the fill-level word or at the next pop, as a misordered or missing byte. The bench sweeps all four clock modes, several burst lengths including 1 and 63, and both chip-select polarities. It compares every captured byte and every returned byte against values computed arithmetically.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int REG_AW = 6;
    localparam logic [REG_AW-1:0] A_RXD  = 6'h00;
    localparam logic [REG_AW-1:0] A_TXD  = 6'h04;
    localparam logic [REG_AW-1:0] A_CTRL = 6'h08;
    localparam logic [REG_AW-1:0] A_BLEN = 6'h20;
    localparam logic [REG_AW-1:0] A_SLEN = 6'h24;
    localparam logic [REG_AW-1:0] A_LVL  = 6'h28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_STORE
    } eng_state_t;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : store[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) store[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    // R3: the fill level never passes the depth
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R3: a push into a full queue leaves the level unchanged
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));

    // R4: a pop of an empty queue leaves it empty
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (level == '0));
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] send_len,
    input  logic             tick,
    input  logic             tx_empty,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy
);
    eng_state_t       state, nxt;
    logic [CNT_W-1:0] remain, sent;
    logic [2:0]       bitn;
    logic [7:0]       txs, rxs;
    logic [7:0]       ld_byte;
    logic             sclk_r, mosi_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = (bitn == 3'd7) ? ST_STORE : ST_LEAD;
            ST_STORE: nxt = (remain == CNT_W'(1)) ? ST_IDLE : ST_LOAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign tx_pop  = (state == ST_LOAD) && (sent < send_len) && !tx_empty;
    assign ld_byte = tx_pop ? tx_data : 8'h00;
    assign rx_push = (state == ST_STORE);
    assign rx_data = rxs;
    assign busy    = (state != ST_IDLE);
    assign sclk    = sclk_r;
    assign mosi    = mosi_r;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            sent   <= '0;
            bitn   <= '0;
            txs    <= '0;
            rxs    <= '0;
            sclk_r <= 1'b0;
            mosi_r <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_r <= cpol;
                    if (start) begin
                        remain <= burst_len;
                        sent   <= '0;
                    end
                end
                ST_LOAD: begin
                    sent <= sent + 1'b1;
                    bitn <= '0;
                    if (!cpha) begin
                        mosi_r <= ld_byte[7];
                        txs    <= {ld_byte[6:0], 1'b0};
                    end else begin
                        txs <= ld_byte;
                    end
                end
                ST_LEAD: if (tick) begin
                    sclk_r <= ~sclk_r;
                    if (!cpha) rxs <= {rxs[6:0], miso};
                    else begin
                        mosi_r <= txs[7];
                        txs    <= {txs[6:0], 1'b0};
                    end
                end
                ST_TRAIL: if (tick) begin
                    sclk_r <= ~sclk_r;
                    bitn   <= bitn + 1'b1;
                    if (cpha) rxs <= {rxs[6:0], miso};
                    else begin
                        mosi_r <= txs[7];
                        txs    <= {txs[6:0], 1'b0};
                    end
                end
                ST_STORE: remain <= remain - 1'b1;
                default: ;
            endcase
        end
    end

    // R12: during a burst the clock moves only after a tick
    a_r12_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sclk != $past(sclk))) |-> $past(tick));

    // R9: the clock rests at the polarity level while idle
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

    // R8: a burst ends after whole clock periods
    a_r8_whole_periods: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sclk == cpol));
endmodule

// File: rtl/sfc_csgen.sv
module sfc_csgen #(
    parameter int N_CS  = 4,
    parameter int SEL_W = $clog2(N_CS)
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             manual,
    input  logic             man_level,
    input  logic             act_low,
    input  logic             busy,
    output logic [N_CS-1:0]  cs
);
    for (genvar gi = 0; gi < N_CS; gi++) begin : g_line
        always_comb begin
            if (sel != SEL_W'(gi)) cs[gi] = act_low;
            else if (manual)       cs[gi] = man_level;
            else                   cs[gi] = busy ? ~act_low : act_low;
        end
    end
endmodule

// File: rtl/spim_fifo_ctrl.sv
module spim_fifo_ctrl
    import sfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 24,
    parameter int N_CS       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  sclk_tick,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic [N_CS-1:0]       cs_line
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int SEL_W = $clog2(N_CS);

    logic             en_q, mst_q, cpha_q, cpol_q, clow_q, man_q, lvl_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] blen_q, slen_q;
    logic             wr_ctrl, tx_flush, rx_flush, start;
    logic             tx_push, rx_pop, tx_pop, rx_push, busy;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [31:0]      ctrl_rd, lvl_rd;

    assign wr_ctrl  = bus_en && bus_wr && (bus_addr == A_CTRL);
    assign tx_flush = wr_ctrl && bus_wdata[8];
    assign rx_flush = wr_ctrl && bus_wdata[9];
    assign start    = wr_ctrl && bus_wdata[10] && bus_wdata[0]
                      && (blen_q != '0) && !busy;
    assign tx_push  = bus_en && bus_wr && (bus_addr == A_TXD);
    assign rx_pop   = bus_en && !bus_wr && (bus_addr == A_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {en_q, mst_q, cpha_q, cpol_q, clow_q, man_q, lvl_q} <= '0;
            sel_q  <= '0;
            blen_q <= '0;
            slen_q <= '0;
        end else if (bus_en && bus_wr) begin
            if (bus_addr == A_CTRL) begin
                en_q   <= bus_wdata[0];
                mst_q  <= bus_wdata[1];
                cpha_q <= bus_wdata[2];
                cpol_q <= bus_wdata[3];
                clow_q <= bus_wdata[4];
                sel_q  <= bus_wdata[12 +: SEL_W];
                man_q  <= bus_wdata[16];
                lvl_q  <= bus_wdata[17];
            end
            if (bus_addr == A_BLEN) blen_q <= bus_wdata[CNT_W-1:0];
            if (bus_addr == A_SLEN) slen_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[0]           = en_q;
        ctrl_rd[1]           = mst_q;
        ctrl_rd[2]           = cpha_q;
        ctrl_rd[3]           = cpol_q;
        ctrl_rd[4]           = clow_q;
        ctrl_rd[10]          = busy;
        ctrl_rd[12 +: SEL_W] = sel_q;
        ctrl_rd[16]          = man_q;
        ctrl_rd[17]          = lvl_q;
        lvl_rd               = '0;
        lvl_rd[LVL_W-1:0]    = rx_lvl;
        lvl_rd[16 +: LVL_W]  = tx_lvl;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RXD:   bus_rdata[7:0] = rx_head;
            A_CTRL:  bus_rdata = ctrl_rd;
            A_BLEN:  bus_rdata[CNT_W-1:0] = blen_q;
            A_SLEN:  bus_rdata[CNT_W-1:0] = slen_q;
            A_LVL:   bus_rdata = lvl_rd;
            default: bus_rdata = '0;
        endcase
    end

    sfc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head),
        .level(tx_lvl), .empty(tx_empty), .full(tx_full)
    );

    sfc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head),
        .level(rx_lvl), .empty(rx_empty), .full(rx_full)
    );

    sfc_engine #(.CNT_W(CNT_W)) i_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cpol(cpol_q), .cpha(cpha_q),
        .burst_len(blen_q), .send_len(slen_q), .tick(sclk_tick),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    sfc_csgen #(.N_CS(N_CS), .SEL_W(SEL_W)) i_cs (
        .sel(sel_q), .manual(man_q), .man_level(lvl_q),
        .act_low(clow_q), .busy(busy), .cs(cs_line)
    );

    logic [N_CS-1:0] cs_active;
    assign cs_active = clow_q ? ~cs_line : cs_line;

    // R11: at most one line is ever active
    a_r11_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_active));

    // R11: the selected line is active for the whole automatic burst
    a_r11_auto_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !man_q) |-> cs_active[sel_q]);

    // R7: a start request turns the busy bit on in the next cycle
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8: no received byte is lost inside a legal burst
    a_r8_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop) |-> !rx_full || rx_flush);
endmodule

// File: tb/test_spim_fifo_ctrl.sv
module test_spim_fifo_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_tick = 1'b0;
    logic        miso;
    logic        sclk, mosi;
    logic [3:0]  cs_line;

    int n_chk = 0, n_bad = 0;
    int k = 0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_low = 1'b0;
    logic [7:0] got [64];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) sclk_tick <= ~sclk_tick;

    spim_fifo_ctrl i_spim_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_tick(sclk_tick), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_line(cs_line)
    );

    function automatic logic [7:0] resp(int i);
        return 8'h5A ^ 8'(i * 29);
    endfunction

    function automatic logic [7:0] txb(int i, int m, int n);
        return 8'(i * 53 + m * 7 + n);
    endfunction

    function automatic logic [31:0] mkc(bit en, bit pha, bit pol, bit low,
                                        int sel, bit man, bit lvl,
                                        bit txr, bit rxr, bit go);
        logic [31:0] v;
        v = '0;
        v[0] = en; v[1] = 1'b1; v[2] = pha; v[3] = pol; v[4] = low;
        v[8] = txr; v[9] = rxr; v[10] = go;
        v[13:12] = 2'(sel); v[16] = man; v[17] = lvl;
        return v;
    endfunction

    // bench slave: answers resp(byte) MSB first, records what it samples
    assign miso = resp(k / 8)[7 - (k % 8)];
    always @(sclk) begin
        if (rst_n && ((sclk != cfg_cpol) == !cfg_cpha) && k < 512) begin
            got[k / 8] = {got[k / 8][6:0], mosi};
            k = k + 1;
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  cs_exp;
        int lens [4] = '{1, 2, 17, 63};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd(6'h08, d);  chk(d == 0, "R1 ctrl", d, 0);
        rd(6'h28, d);  chk(d == 0, "R1 levels", d, 0);
        chk(cs_line == 4'b0000, "R1 cs", 32'(cs_line), 0);
        chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);

        // R2: 24-bit length words
        wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, d);
        chk(d == 32'h00FF_FFFF, "R2 burst len", d, 32'h00FF_FFFF);
        wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d);
        chk(d == 32'h00FF_FFFF, "R2 send len", d, 32'h00FF_FFFF);

        // R7: start without enable is ignored
        wr(6'h20, 5);
        wr(6'h08, mkc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1));
        rd(6'h08, d);
        chk(d[10] == 1'b0, "R7 start ignored", d, mkc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
        chk(cs_line == 4'b0000, "R7 no cs", 32'(cs_line), 0);

        // R8 R9 R10 R11 R5 R4: sweep modes and lengths
        for (int m = 0; m < 4; m++) begin
            for (int li = 0; li < 4; li++) begin
                int n, sl, guard;
                n = lens[li];
                sl = (li == 2 && m == 1) ? 10 : n;
                cfg_cpha = m[0]; cfg_cpol = m[1]; cfg_low = m[0] ^ m[1];
                wr(6'h08, mkc(1, cfg_cpha, cfg_cpol, cfg_low, m, 0, 0, 1, 1, 0));
                repeat (3) @(negedge clk);
                k = 0;
                for (int i = 0; i < 64; i++) got[i] = 8'hxx;
                for (int i = 0; i < sl; i++) wr(6'h04, 32'(txb(i, m, n)));
                wr(6'h20, n);
                wr(6'h24, sl);
                rd(6'h28, d);
                chk(d == (32'(sl) << 16), "R5 tx level", d, 32'(sl) << 16);
                wr(6'h08, mkc(1, cfg_cpha, cfg_cpol, cfg_low, m, 0, 0, 0, 0, 1));
                rd(6'h08, d);
                chk(d[10] == 1'b1, "R7 busy", d, 32'h400);
                cs_exp = cfg_low ? ~(4'b1 << m) : (4'b1 << m);
                chk(cs_line == cs_exp, "R11 auto cs", 32'(cs_line), 32'(cs_exp));
                guard = 0;
                while (d[10] && guard < 20000) begin
                    rd(6'h08, d);
                    guard++;
                end
                chk(d[10] == 1'b0, "R7 self clear", d, 0);
                chk(k == 8 * n, "R8 bit count", k, 8 * n);
                for (int i = 0; i < n; i++) begin
                    logic [7:0] e;
                    e = (i < sl) ? txb(i, m, n) : 8'h00;
                    chk(got[i] === e, (i < sl) ? "R8 mosi byte" : "R10 dummy byte",
                        32'(got[i]), 32'(e));
                end
                chk(sclk == cfg_cpol, "R9 idle level", 32'(sclk), 32'(cfg_cpol));
                cs_exp = cfg_low ? 4'b1111 : 4'b0000;
                chk(cs_line == cs_exp, "R11 released", 32'(cs_line), 32'(cs_exp));
                rd(6'h28, d);
                chk(d == 32'(n), "R5 rx level", d, 32'(n));
                for (int i = 0; i < n; i++) begin
                    rd(6'h00, d);
                    chk(d == 32'(resp(i)), "R4 rx byte", d, 32'(resp(i)));
                end
            end
        end

        // R4: empty read
        rd(6'h00, d); chk(d == 0, "R4 empty read", d, 0);
        rd(6'h28, d); chk(d == 0, "R4 empty level", d, 0);

        // R3: full queue drops writes
        cfg_cpha = 0; cfg_cpol = 0; cfg_low = 0;
        wr(6'h08, mkc(1, 0, 0, 0, 0, 0, 0, 1, 1, 0));
        for (int i = 0; i < 66; i++) wr(6'h04, i);
        rd(6'h28, d);
        chk(d == (32'd64 << 16), "R3 full level", d, 32'd64 << 16);

        // R6: queue reset bits
        wr(6'h08, mkc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        rd(6'h28, d); chk(d == 0, "R6 tx flush", d, 0);
        rd(6'h08, d); chk(d[9:8] == 2'b00, "R6 bits read 0", d, mkc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(6'h20, 3);
        wr(6'h08, mkc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        repeat (200) @(negedge clk);
        rd(6'h28, d); chk(d == 3, "R6 rx filled", d, 3);
        wr(6'h08, mkc(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        rd(6'h28, d); chk(d == 0, "R6 rx flush", d, 0);

        // R11: manual chip select
        wr(6'h08, mkc(1, 0, 0, 1, 2, 1, 1, 0, 0, 0));
        #1 chk(cs_line == 4'b1111, "R11 manual high low-act", 32'(cs_line), 32'hF);
        wr(6'h08, mkc(1, 0, 0, 1, 2, 1, 0, 0, 0, 0));
        #1 chk(cs_line == 4'b1011, "R11 manual low", 32'(cs_line), 32'hB);
        wr(6'h08, mkc(1, 0, 0, 0, 3, 1, 1, 0, 0, 0));
        #1 chk(cs_line == 4'b1000, "R11 manual high-act", 32'(cs_line), 32'h8);

        finish_run();
    end
endmodule